// File: doc/BRIEF.md
# Doppler Sweep Phase-Increment Generator

This block steps a carrier-wipeoff frequency through a linear series of Doppler bins for an acquisition search. A start pulse captures three settings: a signed starting increment, a signed step increment and a sweep count. The block then feeds a 32-bit phase accumulator with the current increment. Each increment is a signed Q31 fraction of pi radians per sample, so 2^31 stands for +pi and -2^31 for -pi. A frequency f at sample rate fs therefore maps to 2*f/fs*2^31.

The phase words leave the block on a valid/ready stream. A word is offered while a search is running. The accumulator advances by the current increment only when a word is accepted (valid and ready both high). While ready is low, the offered word is held unchanged. Valid never depends on ready.

When the correlator pulses its end-of-sweep input, the block moves to the next bin. It adds the step to the increment, bumps the bin index and clears the phase. On the final bin the block raises a last-sweep flag. The next end-of-sweep pulse then halts the block, and it waits for a new start.

Top module: `dopp_sweep_gen`

## Requirements
- R1: After reset, busy, ph_valid and last_sweep are 0, and bin_idx, ph_inc and ph_word are 0.
- R2: A start pulse takes effect at the next clock edge: ph_inc equals cfg_inc_min, bin_idx is 0, ph_word is 0 and busy is 1. Start takes precedence over sweep_end in the same cycle, and it also restarts a search that is already running.
- R3: A sweep_end pulse while busy and not on the final bin takes effect at the next edge: ph_inc grows by the captured step modulo 2^32, bin_idx grows by one and ph_word returns to 0.
- R4: ph_valid equals busy. Each accepted word (ph_valid and ph_ready high) advances ph_word by ph_inc modulo 2^32 at the next edge.
- R5: While ph_ready is low, ph_word does not change.
- R6: last_sweep is 1 exactly when bin_idx equals the captured count minus one. A captured count of 0 acts as a count of 1. The flag stays high after the block halts, until the next start.
- R7: A sweep_end on the final bin clears busy and ph_valid and returns ph_word to 0. It leaves ph_inc and bin_idx unchanged.
- R8: While idle, sweep_end and ph_ready have no effect on any output.
- R9: The cfg_* inputs are sampled only on a start pulse. Changing them during a search has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a new search, capturing the cfg_* inputs |
| cfg_inc_min | input | 32 | Signed Q31 increment of the first bin |
| cfg_inc_step | input | 32 | Signed Q31 increment added per bin |
| cfg_sweeps | input | 8 | Number of bins (0 treated as 1) |
| sweep_end | input | 1 | Correlator pulse: current bin finished |
| ph_valid | output | 1 | Phase word offered |
| ph_ready | input | 1 | Consumer accepts the phase word |
| ph_word | output | 32 | Accumulated carrier phase |
| ph_inc | output | 32 | Current signed Q31 increment |
| bin_idx | output | 8 | Index of the bin being processed |
| last_sweep | output | 1 | Current bin is the final one |
| busy | output | 1 | Search in progress |

## Verification
Three situations need deliberate stimulus. The first is an increment that wraps through the signed limit while stepping. The bench reaches it by choosing a start value just below +2^31 with a positive step, and one just above -2^31 with a negative step. The second is a sweep_end that arrives in the same cycle as an accepted word. The third is a start that collides with a sweep_end in the middle of a search. The bench drives each collision explicitly. It runs every count from 0 to 5 with a ready pattern that shifts per bin, and it computes each expected phase as a running modular sum.

// File: rtl/dsg_pkg.sv
package dsg_pkg;
  localparam int PH_W = 32;
  typedef logic [PH_W-1:0] ph_t;

  function automatic ph_t ph_add(input ph_t a, input ph_t b);
    return a + b;
  endfunction
endpackage

// File: rtl/dsg_sweep_ctrl.sv
module dsg_sweep_ctrl #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sweep_end,
  input  logic [IDX_W-1:0] cfg_sweeps,
  output logic             load,
  output logic             adv,
  output logic             sweep_clr,
  output logic [IDX_W-1:0] bin_idx,
  output logic             last_sweep,
  output logic             busy
);
  localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

  logic [IDX_W-1:0] lim_q, idx_q;
  logic             busy_q;
  logic             end_take, at_last;

  assign at_last   = (idx_q == lim_q);
  assign end_take  = busy_q && sweep_end && !start;
  assign load      = start;
  assign adv       = end_take && !at_last;
  assign sweep_clr = start || end_take;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '1;
      idx_q  <= '0;
      busy_q <= 1'b0;
    end else if (start) begin
      lim_q  <= (cfg_sweeps == '0) ? '0 : cfg_sweeps - IDX_ONE;
      idx_q  <= '0;
      busy_q <= 1'b1;
    end else if (end_take) begin
      if (at_last) busy_q <= 1'b0;
      else         idx_q  <= idx_q + IDX_ONE;
    end
  end

  assign bin_idx    = idx_q;
  assign last_sweep = at_last;
  assign busy       = busy_q;

  // R2
  start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && bin_idx == '0));
  // R7
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sweep_end && !start && last_sweep) |=> (!busy && $stable(bin_idx)));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> (!busy && $stable(bin_idx)));
  // R6
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (bin_idx <= lim_q));
endmodule

// File: rtl/dsg_inc_reg.sv
module dsg_inc_reg
  import dsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic adv,
  input  ph_t  cfg_inc_min,
  input  ph_t  cfg_inc_step,
  output ph_t  inc
);
  ph_t inc_q, step_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      inc_q  <= '0;
      step_q <= '0;
    end else if (load) begin
      inc_q  <= cfg_inc_min;
      step_q <= cfg_inc_step;
    end else if (adv) begin
      inc_q  <= ph_add(inc_q, step_q);
    end
  end

  assign inc = inc_q;

  // R2
  inc_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (inc == $past(cfg_inc_min)));
  // R3
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> (inc == $past(inc) + step_q));
  // R9
  inc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !adv) |=> $stable(inc));
endmodule

// File: rtl/dsg_phase_acc.sv
module dsg_phase_acc
  import dsg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  ph_t  inc,
  output logic ph_valid,
  input  logic ph_ready,
  output ph_t  ph_word
);
  ph_t acc_q;

  assign ph_valid = run;

  always_ff @(posedge clk) begin
    if (!rst_n)                   acc_q <= '0;
    else if (clr)                 acc_q <= '0;
    else if (ph_valid && ph_ready) acc_q <= ph_add(acc_q, inc);
  end

  assign ph_word = acc_q;

  // R5
  backpressure_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && !ph_ready && !clr) |=> $stable(ph_word));
  // R4
  accept_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_valid && ph_ready && !clr) |=> (ph_word == $past(ph_word) + $past(inc)));
  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ph_word == '0));
endmodule

// File: rtl/dopp_sweep_gen.sv
module dopp_sweep_gen
  import dsg_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [31:0]      cfg_inc_min,
  input  logic [31:0]      cfg_inc_step,
  input  logic [IDX_W-1:0] cfg_sweeps,
  input  logic             sweep_end,
  output logic             ph_valid,
  input  logic             ph_ready,
  output logic [31:0]      ph_word,
  output logic [31:0]      ph_inc,
  output logic [IDX_W-1:0] bin_idx,
  output logic             last_sweep,
  output logic             busy
);
  logic load, adv, sweep_clr;
  ph_t  inc_w, word_w;

  dsg_sweep_ctrl #(.IDX_W(IDX_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .start(start), .sweep_end(sweep_end),
    .cfg_sweeps(cfg_sweeps), .load(load), .adv(adv), .sweep_clr(sweep_clr),
    .bin_idx(bin_idx), .last_sweep(last_sweep), .busy(busy)
  );

  dsg_inc_reg inc_i (
    .clk(clk), .rst_n(rst_n), .load(load), .adv(adv),
    .cfg_inc_min(cfg_inc_min), .cfg_inc_step(cfg_inc_step), .inc(inc_w)
  );

  dsg_phase_acc acc_i (
    .clk(clk), .rst_n(rst_n), .run(busy), .clr(sweep_clr), .inc(inc_w),
    .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_word(word_w)
  );

  assign ph_inc  = inc_w;
  assign ph_word = word_w;

  // R4
  valid_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ph_valid == busy);
endmodule

// File: tb/dopp_sweep_gen_tb_top.sv
module dopp_sweep_gen_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, sweep_end = 1'b0, ph_ready = 1'b0;
  logic [31:0] cfg_inc_min = '0, cfg_inc_step = '0;
  logic [7:0]  cfg_sweeps = '0;
  logic        ph_valid, last_sweep, busy;
  logic [31:0] ph_word, ph_inc;
  logic [7:0]  bin_idx;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  dopp_sweep_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_inc_min(cfg_inc_min),
    .cfg_inc_step(cfg_inc_step), .cfg_sweeps(cfg_sweeps), .sweep_end(sweep_end),
    .ph_valid(ph_valid), .ph_ready(ph_ready), .ph_word(ph_word), .ph_inc(ph_inc),
    .bin_idx(bin_idx), .last_sweep(last_sweep), .busy(busy)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s: got=%h exp=%h", req, what, got, exp);
    end
  endtask

  // Check the whole visible state at a falling edge.
  task automatic chk_state(input string req, input logic [31:0] e_inc,
                           input logic [7:0] e_idx, input logic e_last,
                           input logic e_busy, input logic [31:0] e_ph);
    chk(req, "ph_inc", ph_inc, e_inc);
    chk(req, "bin_idx", {24'd0, bin_idx}, {24'd0, e_idx});
    chk(req, "last_sweep", {31'd0, last_sweep}, {31'd0, e_last});
    chk(req, "busy", {31'd0, busy}, {31'd0, e_busy});
    chk(req, "ph_valid", {31'd0, ph_valid}, {31'd0, e_busy});
    chk(req, "ph_word", ph_word, e_ph);
  endtask

  task automatic run_search(input logic [31:0] mn, input logic [31:0] st,
                            input logic [7:0] cnt);
    int n;
    logic [31:0] e_inc, e_ph;
    n = (cnt == 0) ? 1 : int'(cnt);
    @(negedge clk);
    start = 1'b1; cfg_inc_min = mn; cfg_inc_step = st; cfg_sweeps = cnt;
    @(negedge clk);
    start = 1'b0;
    // R9: scramble the configuration during the search
    cfg_inc_min = ~mn; cfg_inc_step = st ^ 32'h5A5A_0F0F; cfg_sweeps = cnt + 8'd3;
    e_inc = mn;
    for (int j = 0; j < n; j++) begin
      e_ph = '0;
      chk("R2 R3 R6 R9", "bin entry", 32'd0, 32'd0);
      chk_state("R3 R6 R9", e_inc, 8'(j), (j == n - 1), 1'b1, e_ph);
      for (int s = 0; s < 6; s++) begin
        logic rdy;
        rdy = ((s + j) % 3) != 0;
        ph_ready = rdy;
        @(negedge clk);
        if (rdy) e_ph = e_ph + e_inc;
        chk(rdy ? "R4" : "R5", "ph_word", ph_word, e_ph);
      end
      // sweep_end together with an accepted word: clear wins
      sweep_end = 1'b1; ph_ready = 1'b1;
      @(negedge clk);
      sweep_end = 1'b0; ph_ready = 1'b0;
      if (j < n - 1) e_inc = e_inc + st;
    end
    // R7: halted, increment and index kept, last flag held (R6)
    chk_state("R7 R6", e_inc, 8'(n - 1), 1'b1, 1'b0, 32'd0);
    // R8: idle inputs ignored
    sweep_end = 1'b1; ph_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    sweep_end = 1'b0; ph_ready = 1'b0;
    chk_state("R8", e_inc, 8'(n - 1), 1'b1, 1'b0, 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL watchdog: got=timeout exp=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk_state("R1", 32'd0, 8'd0, 1'b0, 1'b0, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk_state("R1", 32'd0, 8'd0, 1'b0, 1'b0, 32'd0);
    // R8: sweep_end before any start
    sweep_end = 1'b1; ph_ready = 1'b1;
    @(negedge clk);
    sweep_end = 1'b0; ph_ready = 1'b0;
    chk_state("R8", 32'd0, 8'd0, 1'b0, 1'b0, 32'd0);

    for (int c = 0; c <= 5; c++) begin
      run_search(32'hFFFF_8000, 32'h0000_4000, 8'(c));
      run_search(32'h7FFF_F000, 32'h0000_0900, 8'(c));   // positive wrap
      run_search(32'h8000_0100, 32'hFFFF_FF00, 8'(c));   // negative wrap
      run_search(32'h1234_5678, 32'd0, 8'(c));
    end

    // R2: start colliding with sweep_end mid-search, and restart
    @(negedge clk);
    start = 1'b1; cfg_inc_min = 32'h0000_1000; cfg_inc_step = 32'h0000_0100; cfg_sweeps = 8'd4;
    @(negedge clk);
    start = 1'b0;
    sweep_end = 1'b1;
    @(negedge clk);
    sweep_end = 1'b0; ph_ready = 1'b1;
    chk_state("R3", 32'h0000_1100, 8'd1, 1'b0, 1'b1, 32'd0);
    @(negedge clk);
    chk("R4", "ph_word", ph_word, 32'h0000_1100);
    start = 1'b1; sweep_end = 1'b1; cfg_inc_min = 32'hF000_0000; cfg_sweeps = 8'd2;
    @(negedge clk);
    start = 1'b0; sweep_end = 1'b0; ph_ready = 1'b0;
    chk_state("R2", 32'hF000_0000, 8'd0, 1'b0, 1'b1, 32'd0);
    sweep_end = 1'b1;
    @(negedge clk);
    sweep_end = 1'b0;
    chk_state("R3 R6", 32'hF000_0100, 8'd1, 1'b1, 1'b1, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule